// File: doc/BRIEF.md
# Receive Address Filter and Ring Buffer Writer

This block takes an incoming Ethernet frame as a stream of bytes, one per clock, marked by a valid flag and a last-byte flag. It decides whether to keep the frame by looking at the destination address. The decision uses a receive mode byte, a programmed station address and a 64-bit multicast hash table. A kept frame is stored in packet memory inside a circular buffer made of 256-byte pages, which the surrounding logic bounds by first-page and end-page registers. Each frame starts on the current write page with a 4-byte header.

At the start of a frame the block checks the halt control and the free space between the write page and the read page. A frame that cannot be stored is refused outright and writes nothing. An admitted frame is written byte by byte from four bytes past the start of the write page. Once the last byte has arrived and the frame has been padded to the minimum length, the header is written. The block then issues a write-page update and a one-cycle receive-done pulse.

The state machine has six states:

- IDLE: waits for a first byte. It takes IDLE→DROP on a refused multi-byte frame, IDLE→RECV on an admitted frame, and IDLE→PAD on an admitted single-byte frame.
- RECV: stores bytes. It takes RECV→PAD on a last byte below minimum length, RECV→HDR on a last byte that the filter accepts, and RECV→IDLE on a last byte that the filter rejects.
- PAD: stores zero bytes. It takes PAD→HDR or PAD→IDLE when the minimum length is reached.
- HDR: writes the four header bytes, then takes HDR→COMMIT.
- COMMIT: issues the pulses, then takes COMMIT→IDLE.
- DROP: discards bytes of a refused frame, and takes DROP→IDLE on its last byte.

Top module: `rx_frame_ring`

## Requirements
- R1: A frame whose first byte arrives while `rx_halt` is 1, or while `ring_end_pg` <= `ring_first_pg`, is refused: it causes no memory write and no write-page update.
- R2: Addresses are page numbers times 256, with W the write address, B the read address and S to E the ring span. Free space is B−W when W < B, and otherwise (E−S)−(W−B). A frame whose first byte sees free space below 1518 bytes is refused with no write and no update.
- R3: When `rx_mode` bit 4 is 1, every admitted frame is accepted, whatever its destination.
- R4: When bit 4 is 0, a destination of all 0xFF bytes is accepted only if `rx_mode` bit 2 is 1.
- R5: Any other destination whose first byte has bit 0 set is a group address. It is accepted only if `rx_mode` bit 3 is 1 and bit `idx` of `hash_table` is 1. The index `idx` is bits 31:26 of a CRC-32 over the six destination bytes, taken in wire order with each byte fed from its least significant bit. The CRC uses polynomial 0x04C11DB7, starts at all ones and has no final inversion. Table byte k is `hash_table[8k+7:8k]`.
- R6: Any other destination is accepted only if its six bytes equal `station_mac`. Byte k on the wire must equal `station_mac[8k+7:8k]`.
- R7: A frame shorter than 60 bytes is extended with zero bytes to 60 bytes, and the padded length is used everywhere.
- R8: The header occupies addresses P*256+0..3, where P is the write page at frame start. It holds, in this order: a status byte, the next page, and the length L+4 low byte then high byte, where L is the padded length. The status byte has bit 0 = 1, and bit 5 = 1 exactly when bit 0 of the first destination byte is 1.
- R9: Frame byte i is stored in order from P*256+4. Each step that would reach `ring_end_pg`*256 moves to `ring_first_pg`*256 instead.
- R10: The next page is P + ceil((L+8)/256). If that is >= `ring_end_pg`, it is reduced by (`ring_end_pg`−`ring_first_pg`). After the header, `wpg_load` and `rx_done` are both 1 for one cycle, with `wpg_next` equal to the next page.
- R11: A frame that fails the address filter writes no header and causes no `wpg_load` or `rx_done`.
- R12: Under reset, `mem_we`, `wpg_load` and `rx_done` are 0.
- R13: `in_valid` is 0 from the cycle after a frame's last byte until the block is idle again. A gap of 70 cycles is always enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| rx_halt | input | 1 | Halt: refuse new frames |
| rx_mode | input | 8 | Bit 2 broadcast, bit 3 group hash, bit 4 accept all |
| station_mac | input | 48 | Station address, wire byte k at bits 8k+7:8k |
| hash_table | input | 64 | Group hash table |
| ring_first_pg | input | PG_W | First page of the ring |
| ring_end_pg | input | PG_W | Page just past the ring |
| read_pg | input | PG_W | Oldest page not yet read |
| write_pg | input | PG_W | Current write page |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| wpg_load | output | 1 | Load `wpg_next` into the write page |
| wpg_next | output | PG_W | New write page |
| rx_done | output | 1 | Receive-OK pulse |

## Verification
The bench attacks the free-space threshold from both sides: one page short of 1518 bytes must be refused and one page over must be stored. The space check is also exercised with the write page behind the read page and with it ahead, so a design that mixes up the two formulas either admits a frame over unread data or refuses a nearly empty ring.

A 600-byte frame starting on the last ring page must wrap both its data and its next-page number. A design that wraps late writes outside the ring, and one that forgets the subtraction hands out a page beyond the end.

Group frames are run with the selected hash bit set, with it clear but every other bit set, and with group reception disabled. Together these expose a wrong CRC bit order or a wrong table index.

A 20-byte frame checks that the zero padding and the length field use 60 bytes. Near-miss unicast and broadcast frames with the mode bit off check that a rejected frame leaves the write page untouched.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_PAD,
        ST_HDR,
        ST_COMMIT,
        ST_DROP
    } rfr_state_e;

    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam int          HDR_LEN   = 4;
    localparam int          PAGE_SH   = 8;

    // rx_mode bit positions
    localparam int MODE_BCAST   = 2;
    localparam int MODE_GROUP   = 3;
    localparam int MODE_PROMISC = 4;

    // status byte bits
    localparam logic [7:0] STAT_OK  = 8'h01;
    localparam logic [7:0] STAT_GRP = 8'h20;

    // One byte of the serial CRC, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rfr_dest_filter.sv
module rfr_dest_filter
    import rfr_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    feed,
    input  logic                    first,
    input  logic [7:0]              din,
    input  logic [8*ADDR_BYTES-1:0] station_mac,
    input  logic [63:0]             hash_table,
    input  logic [7:0]              rx_mode,
    output logic                    accept,
    output logic                    group
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);

    logic [IDX_W-1:0] seen, seen_b;
    logic [31:0]      crc, crc_b;
    logic             all_ones, all_ones_b;
    logic             uni_eq, uni_eq_b;
    logic             grp, grp_b;
    logic             in_addr;
    logic [7:0]       st_byte;
    logic [5:0]       hash_idx;
    logic             hash_hit;

    // Frame start restarts the accumulation.
    always_comb begin
        if (first) begin
            seen_b     = '0;
            crc_b      = '1;
            all_ones_b = 1'b1;
            uni_eq_b   = 1'b1;
            grp_b      = 1'b0;
        end else begin
            seen_b     = seen;
            crc_b      = crc;
            all_ones_b = all_ones;
            uni_eq_b   = uni_eq;
            grp_b      = grp;
        end
    end

    assign in_addr = (seen_b < IDX_W'(ADDR_BYTES));

    always_comb begin
        st_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (seen_b == IDX_W'(k)) st_byte = station_mac[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= '0;
            crc      <= '1;
            all_ones <= 1'b0;
            uni_eq   <= 1'b0;
            grp      <= 1'b0;
        end else if (feed && in_addr) begin
            seen     <= seen_b + 1'b1;
            crc      <= crc_step(crc_b, din);
            all_ones <= all_ones_b & (din == 8'hFF);
            uni_eq   <= uni_eq_b & (din == st_byte);
            grp      <= (seen_b == '0) ? din[0] : grp_b;
        end
    end

    assign hash_idx = crc[31:26];
    assign hash_hit = hash_table[hash_idx];

    always_comb begin
        if (rx_mode[MODE_PROMISC])  accept = 1'b1;
        else if (all_ones)          accept = rx_mode[MODE_BCAST];
        else if (grp)               accept = rx_mode[MODE_GROUP] & hash_hit;
        else                        accept = uni_eq;
    end

    assign group = grp;

    // R8: the group flag follows bit 0 of the first destination byte
    assert_group_tracks_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && first) |=> (group == $past(din[0])));

endmodule

// File: rtl/rfr_space_check.sv
module rfr_space_check
    import rfr_pkg::*;
#(
    parameter int PG_W = 8,
    parameter int NEED = 1518
) (
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] end_pg,
    input  logic [PG_W-1:0] read_pg,
    input  logic [PG_W-1:0] write_pg,
    output logic            full
);
    localparam int SW = PG_W + PAGE_SH + 2;

    logic signed [SW-1:0] s_a, e_a, b_a, w_a, avail;

    always_comb begin
        s_a = $signed({2'b00, first_pg, 8'h00});
        e_a = $signed({2'b00, end_pg,   8'h00});
        b_a = $signed({2'b00, read_pg,  8'h00});
        w_a = $signed({2'b00, write_pg, 8'h00});
        if (w_a < b_a) avail = b_a - w_a;
        else           avail = (e_a - s_a) - (w_a - b_a);
        full = (end_pg <= first_pg) || (avail < $signed(SW'(NEED)));
    end

endmodule

// File: rtl/rfr_store_fsm.sv
module rfr_store_fsm
    import rfr_pkg::*;
#(
    parameter int PG_W    = 8,
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    input  logic                  halt,
    input  logic                  full,
    input  logic                  accept,
    input  logic                  group,
    input  logic [PG_W-1:0]       first_pg,
    input  logic [PG_W-1:0]       end_pg,
    input  logic [PG_W-1:0]       write_pg,
    output logic                  filt_feed,
    output logic                  filt_first,
    output logic [7:0]            filt_byte,
    output logic                  mem_we,
    output logic [PG_W+7:0]       mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  wpg_load,
    output logic [PG_W-1:0]       wpg_next,
    output logic                  rx_done
);
    localparam int AW   = PG_W + PAGE_SH;
    localparam int HI_W = $clog2(HDR_LEN);

    rfr_state_e          state, nxt;
    logic [CNT_W-1:0]    cnt, cnt_n, total, pages, np_raw, span, np;
    logic [AW-1:0]       wr_addr, byte_addr, addr_inc, adv;
    logic [PG_W-1:0]     base_pg, next_pg;
    logic [HI_W-1:0]     hdr_idx;
    logic [7:0]          hdr_byte, byte_d;
    logic                byte_ev, refuse;

    assign refuse    = halt | full;
    assign cnt_n     = (state == ST_IDLE) ? CNT_W'(1) : cnt + CNT_W'(1);
    assign byte_d    = (state == ST_PAD) ? 8'h00 : in_data;
    assign byte_addr = (state == ST_IDLE) ? {write_pg, 8'(HDR_LEN)} : wr_addr;
    assign addr_inc  = byte_addr + AW'(1);
    assign adv       = (addr_inc == {end_pg, 8'h00}) ? {first_pg, 8'h00} : addr_inc;

    always_comb begin
        unique case (state)
            ST_IDLE: byte_ev = in_valid & ~refuse;
            ST_RECV: byte_ev = in_valid;
            ST_PAD:  byte_ev = 1'b1;
            default: byte_ev = 1'b0;
        endcase
    end

    // Next page from padded length and the frame's start page.
    assign total   = cnt + CNT_W'(HDR_LEN);
    assign pages   = (total + CNT_W'(HDR_LEN + 255)) >> PAGE_SH;
    assign np_raw  = CNT_W'(base_pg) + pages;
    assign span    = CNT_W'(end_pg) - CNT_W'(first_pg);
    assign np      = (np_raw >= CNT_W'(end_pg)) ? np_raw - span : np_raw;
    assign next_pg = np[PG_W-1:0];

    always_comb begin
        unique case (hdr_idx)
            2'd0:    hdr_byte = STAT_OK | (group ? STAT_GRP : 8'h00);
            2'd1:    hdr_byte = next_pg;
            2'd2:    hdr_byte = total[7:0];
            default: hdr_byte = total[15:8];
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    if (refuse)       nxt = in_last ? ST_IDLE : ST_DROP;
                    else if (in_last) nxt = ST_PAD;
                    else              nxt = ST_RECV;
                end
            end
            ST_RECV: begin
                if (in_valid && in_last) begin
                    if (cnt_n < CNT_W'(MIN_LEN)) nxt = ST_PAD;
                    else if (accept)             nxt = ST_HDR;
                    else                         nxt = ST_IDLE;
                end
            end
            ST_PAD: begin
                if (cnt_n == CNT_W'(MIN_LEN)) nxt = accept ? ST_HDR : ST_IDLE;
            end
            ST_HDR: begin
                if (hdr_idx == HI_W'(HDR_LEN - 1)) nxt = ST_COMMIT;
            end
            ST_COMMIT: nxt = ST_IDLE;
            ST_DROP: begin
                if (in_valid && in_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign filt_feed  = byte_ev;
    assign filt_first = (state == ST_IDLE);
    assign filt_byte  = byte_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            wr_addr   <= '0;
            base_pg   <= '0;
            hdr_idx   <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            wpg_load  <= 1'b0;
            wpg_next  <= '0;
            rx_done   <= 1'b0;
        end else begin
            if (byte_ev) begin
                cnt     <= cnt_n;
                wr_addr <= adv;
                if (state == ST_IDLE) base_pg <= write_pg;
            end
            hdr_idx   <= (state == ST_HDR) ? hdr_idx + 1'b1 : '0;
            mem_we    <= byte_ev | (state == ST_HDR);
            mem_addr  <= (state == ST_HDR) ? {base_pg, (PAGE_SH - HI_W)'(0), hdr_idx} : byte_addr;
            mem_wdata <= (state == ST_HDR) ? hdr_byte : byte_d;
            wpg_load  <= (state == ST_COMMIT);
            wpg_next  <= next_pg;
            rx_done   <= (state == ST_COMMIT);
        end
    end

    // R1 and R2: a refused first byte produces no write
    assert_refuse_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && refuse) |=> !mem_we);

    // R9: every write lands inside the ring
    assert_addr_in_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && end_pg > first_pg) |->
            (mem_addr >= {first_pg, 8'h00} && mem_addr < {end_pg, 8'h00}));

    // R10: the new write page is a ring page
    assert_next_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wpg_load |-> (wpg_next >= first_pg && wpg_next < end_pg));

    // R8: the done pulse follows a header write
    assert_done_after_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(mem_we));

    // R13: no input bytes while padding, writing the header or committing
    assert_input_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (state == ST_IDLE || state == ST_RECV || state == ST_DROP));

endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring
    import rfr_pkg::*;
#(
    parameter int PG_W    = 8,
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 60,
    parameter int NEED    = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              rx_halt,
    input  logic [7:0]        rx_mode,
    input  logic [47:0]       station_mac,
    input  logic [63:0]       hash_table,
    input  logic [PG_W-1:0]   ring_first_pg,
    input  logic [PG_W-1:0]   ring_end_pg,
    input  logic [PG_W-1:0]   read_pg,
    input  logic [PG_W-1:0]   write_pg,
    output logic              mem_we,
    output logic [PG_W+7:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              wpg_load,
    output logic [PG_W-1:0]   wpg_next,
    output logic              rx_done
);
    logic       full, accept, group;
    logic       filt_feed, filt_first;
    logic [7:0] filt_byte;

    rfr_space_check #(.PG_W(PG_W), .NEED(NEED)) u_space (
        .first_pg (ring_first_pg),
        .end_pg   (ring_end_pg),
        .read_pg  (read_pg),
        .write_pg (write_pg),
        .full     (full)
    );

    rfr_dest_filter #(.ADDR_BYTES(6)) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .feed        (filt_feed),
        .first       (filt_first),
        .din         (filt_byte),
        .station_mac (station_mac),
        .hash_table  (hash_table),
        .rx_mode     (rx_mode),
        .accept      (accept),
        .group       (group)
    );

    rfr_store_fsm #(.PG_W(PG_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .halt       (rx_halt),
        .full       (full),
        .accept     (accept),
        .group      (group),
        .first_pg   (ring_first_pg),
        .end_pg     (ring_end_pg),
        .write_pg   (write_pg),
        .filt_feed  (filt_feed),
        .filt_first (filt_first),
        .filt_byte  (filt_byte),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wpg_load   (wpg_load),
        .wpg_next   (wpg_next),
        .rx_done    (rx_done)
    );

endmodule

// File: tb/rx_frame_ring_test.sv
module rx_frame_ring_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_last, rx_halt;
    logic [7:0]  in_data, rx_mode;
    logic [47:0] station_mac;
    logic [63:0] hash_table;
    logic [7:0]  ring_first_pg, ring_end_pg, read_pg, write_pg;
    logic        mem_we, wpg_load, rx_done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, wpg_next;

    always #5 clk = ~clk;

    rx_frame_ring uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .rx_halt(rx_halt), .rx_mode(rx_mode), .station_mac(station_mac), .hash_table(hash_table),
        .ring_first_pg(ring_first_pg), .ring_end_pg(ring_end_pg), .read_pg(read_pg),
        .write_pg(write_pg), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wpg_load(wpg_load), .wpg_next(wpg_next), .rx_done(rx_done)
    );

    typedef struct {
        logic [7:0] base;
        logic [7:0] nxt;
        logic [7:0] status;
        logic [7:0] rs;
        logic [7:0] re;
        int         total;
    } item_t;

    item_t      sb[$];
    logic [7:0] exp_b[$];
    logic [7:0] frm[$];
    logic [7:0] bmem[int];
    logic [7:0] cur_pg;
    int n_chk = 0, n_fail = 0, wr_cnt = 0, done_cnt = 0;
    bit finished = 0;

    localparam logic [47:0] STATION = 48'h5254_0012_3456;

    assign write_pg = cur_pg;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input int a);
        if (bmem.exists(a)) return bmem[a];
        return 8'hxx;
    endfunction

    // wire-order MAC (byte 0 in the top bits) to port order (byte 0 in the low bits)
    function automatic logic [47:0] to_port(input logic [47:0] m);
        logic [47:0] r;
        for (int k = 0; k < 6; k++) r[8*k +: 8] = m[47-8*k -: 8];
        return r;
    endfunction

    function automatic int hash_index(input logic [47:0] m);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic bit_in = m[47-8*k-7+b];
                logic top = c[31];
                c = c << 1;
                if (top ^ bit_in) c = c ^ 32'h04C1_1DB7;
            end
        end
        return int'(c[31:26]);
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] b, input int total,
                                            input logic [7:0] rs, input logic [7:0] re);
        int p = int'(b) + (total + 4 + 255) / 256;
        if (p >= int'(re)) p = p - (int'(re) - int'(rs));
        return p[7:0];
    endfunction

    task automatic mk(input logic [47:0] dst, input int size, input int seed);
        frm.delete();
        for (int k = 0; k < 6; k++) frm.push_back(dst[47-8*k -: 8]);
        for (int k = 6; k < size; k++) frm.push_back(8'(k * 7 + seed));
    endtask

    task automatic set_ring(input logic [7:0] s, input logic [7:0] e, input logic [7:0] b, input logic [7:0] c);
        @(negedge clk);
        ring_first_pg = s; ring_end_pg = e; read_pg = b; cur_pg = c;
    endtask

    // Driver: pushes expected items, then drives the frame and waits out the gap.
    task automatic send(input bit acc, input bit refused, input string tag);
        int w0 = wr_cnt;
        int d0 = done_cnt;
        logic [7:0] pg0 = cur_pg;
        if (acc) begin
            item_t it;
            int len = (frm.size() < 60) ? 60 : frm.size();
            it.base   = cur_pg;
            it.total  = len + 4;
            it.rs     = ring_first_pg;
            it.re     = ring_end_pg;
            it.nxt    = exp_next(cur_pg, it.total, ring_first_pg, ring_end_pg);
            it.status = 8'h01 | (frm[0][0] ? 8'h20 : 8'h00);
            sb.push_back(it);
            for (int i = 0; i < len; i++) exp_b.push_back((i < frm.size()) ? frm[i] : 8'h00);
        end
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_last  = (i == frm.size() - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (80) @(negedge clk);
        if (acc) begin
            chk(done_cnt == d0 + 1, {tag, " R10 one commit"}, done_cnt - d0, 1);
        end else begin
            chk(done_cnt == d0, {tag, " R11 no commit"}, done_cnt - d0, 0);
            chk(cur_pg == pg0, {tag, " R11 page kept"}, cur_pg, pg0);
            if (refused) chk(wr_cnt == w0, {tag, " R1 R2 no writes"}, wr_cnt - w0, 0);
        end
    endtask

    // Monitor: scores each commit against the queue head.
    task automatic score();
        item_t it;
        int mism = 0;
        int a;
        if (sb.size() == 0) begin
            chk(1'b0, "R11 unexpected commit", wpg_next, 0);
            return;
        end
        it = sb.pop_front();
        a = int'(it.base) * 256;
        chk(wpg_next == it.nxt, "R10 next page", wpg_next, it.nxt);
        chk(rd(a) === it.status, "R8 status byte", rd(a), it.status);
        chk(rd(a + 1) === it.nxt, "R8 next page byte", rd(a + 1), it.nxt);
        chk({rd(a + 3), rd(a + 2)} === 16'(it.total), "R8 length bytes",
            {rd(a + 3), rd(a + 2)}, it.total);
        a = a + 4;
        for (int i = 0; i < it.total - 4; i++) begin
            logic [7:0] e = exp_b.pop_front();
            if (rd(a) !== e) mism++;
            a++;
            if (a == int'(it.re) * 256) a = int'(it.rs) * 256;
        end
        chk(mism == 0, "R9 R7 stored bytes", mism, 0);
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            if (mem_we) begin
                bmem[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end
            if (wpg_load || rx_done)
                chk(wpg_load == rx_done, "R10 load and done together", rx_done, wpg_load);
            if (rx_done) done_cnt++;
            if (wpg_load) begin
                score();
                cur_pg = wpg_next;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int idx;
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; rx_halt = 1'b0;
        rx_mode = 8'h00; station_mac = to_port(STATION); hash_table = '0;
        ring_first_pg = 8'h40; ring_end_pg = 8'h80; read_pg = 8'h40; cur_pg = 8'h40;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(mem_we == 1'b0, "R12 mem_we in reset", mem_we, 0);
        chk(wpg_load == 1'b0, "R12 wpg_load in reset", wpg_load, 0);
        chk(rx_done == 1'b0, "R12 rx_done in reset", rx_done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 unicast match and miss
        mk(STATION, 100, 1);            send(1, 0, "R6 unicast match");
        mk(48'h5254_0012_3457, 100, 2); send(0, 0, "R6 unicast near miss");

        // R4 broadcast
        mk(48'hFFFF_FFFF_FFFF, 80, 3);  send(0, 0, "R4 broadcast off");
        rx_mode = 8'h04;
        mk(48'hFFFF_FFFF_FFFF, 80, 4);  send(1, 0, "R4 broadcast on");

        // R5 group hash
        idx = hash_index(48'h0100_5E00_0001);
        rx_mode = 8'h08; hash_table = 64'd1 << idx;
        mk(48'h0100_5E00_0001, 90, 5);  send(1, 0, "R5 hash bit set");
        hash_table = ~(64'd1 << idx);
        mk(48'h0100_5E00_0001, 90, 6);  send(0, 0, "R5 hash bit clear");
        rx_mode = 8'h00; hash_table = 64'd1 << idx;
        mk(48'h0100_5E00_0001, 90, 7);  send(0, 0, "R5 group mode off");

        // R3 promiscuous
        rx_mode = 8'h10;
        mk(48'h0A0B_0C0D_0E0F, 70, 8);  send(1, 0, "R3 promiscuous");
        rx_mode = 8'h00;

        // R7 short frame padded
        mk(STATION, 20, 9);             send(1, 0, "R7 short frame");

        // R9 R10 wrap of data and next page
        set_ring(8'h40, 8'h50, 8'h48, 8'h4F);
        mk(STATION, 600, 10);           send(1, 0, "R9 wrap");

        // R2 space threshold, write page behind the read page
        set_ring(8'h40, 8'h80, 8'h4D, 8'h48);
        mk(STATION, 100, 11);           send(0, 1, "R2 1280 free");
        set_ring(8'h40, 8'h80, 8'h4E, 8'h48);
        mk(STATION, 100, 12);           send(1, 0, "R2 1536 free");
        // R2 write page ahead of the read page
        set_ring(8'h40, 8'h80, 8'h43, 8'h7E);
        mk(STATION, 100, 13);           send(0, 1, "R2 wrapped 1280 free");

        // R1 halt and empty ring
        set_ring(8'h40, 8'h80, 8'h40, 8'h40);
        rx_halt = 1'b1;
        mk(STATION, 100, 14);           send(0, 1, "R1 halt");
        rx_halt = 1'b0;
        set_ring(8'h80, 8'h80, 8'h80, 8'h80);
        mk(STATION, 100, 15);           send(0, 1, "R1 end at start");

        // R10 largest frame
        set_ring(8'h40, 8'h80, 8'h40, 8'h40);
        mk(STATION, 1514, 16);          send(1, 0, "R10 max frame");

        chk(sb.size() == 0, "R10 all expected commits seen", sb.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule